// File: doc/BRIEF.md
# Register-File Byte Processor Sequencer

This block is a small 8-bit processor core. It holds sixteen 16-bit general registers, and a 4-bit pointer selects which of them acts as the program counter. Each instruction starts with a fetch machine cycle. One or two execute machine cycles follow it. Every machine cycle is a fixed number of master-clock periods. The core executes a reduced instruction subset:
- short branches that rewrite only the low byte of the program counter
- one long branch
- loads and stores through any register
- moves between the byte accumulator and the register halves
- set and clear of a single output bit
- selection of a new program-counter register

The core sits on a byte-wide memory with a 16-bit address. It raises a read strobe for every cycle in which it samples the data bus. It raises a write enable during store cycles. A two-bit state code marks fetch and execute cycles. Two one-clock timing pulses mark the early and late part of each machine cycle. Either stall input freezes the whole core on any clock.

Top module: `seq_core`

## Requirements
- R1: While `rst_ni` is low, and after it rises, all sixteen registers, the accumulator and the pointer are 0 and `q_o` is 0. The core begins a fetch cycle in its first clock: address 0x0000, state code 00, read strobe high.
- R2: A machine cycle lasts CYCLE_CLKS (8) clocks when not stalled. `tp_early_o` is high only in the 2nd clock of each cycle and `tp_late_o` only in the 7th, so consecutive early pulses are 8 clocks apart.
- R3: A fetch cycle puts R[P] on `addr_o`. The byte on `data_i` at the last edge of the cycle becomes the opcode, and R[P] increments by one. Opcode bits [7:4] are the group and bits [3:0] are the register number N.
- R4: Group 0x3 is a short branch. It reads the operand byte at R[P]. If taken, the operand replaces R[P][7:0] and R[P][15:8] is kept. If not taken, R[P] increments by one, which may carry into the high byte. The condition for each value of N:
  - N=0: always taken. N=8: never taken.
  - N=1: taken if Q=1. N=9: taken if Q=0.
  - N=2: taken if D=0. N=A: taken if D≠0.
  - N=3: never taken. N=B: always taken.
  - N=4..7: taken if `flag_i[N-4]`=1. N=C..F: taken if `flag_i[N-12]`=0.
- R5: Opcode 0xC0 takes three cycles. It reads the high byte at R[P], then the low byte at R[P]+1, and loads R[P] with {high, low}.
- R6: 0x8N copies R[N][7:0] into D. 0x9N copies R[N][15:8] into D. 0xAN writes D into R[N][7:0] and keeps R[N][15:8].
- R7: 0x4N reads memory at R[N] into D and increments R[N]. 0x5N puts R[N] on the address, drives D on `data_o` and holds `data_oe_o` high for that whole execute cycle.
- R8: Opcode 0x7B sets Q and 0x7A clears it. `q_o` changes only on the last edge of a machine cycle.
- R9: 0xDN sets P to N, so the next fetch uses R[N].
- R10: Every opcode not named in R4 to R9 is a two-cycle no-operation.
- R11: `state_code_o` is 00 in fetch cycles and 01 in execute cycles, and changes only on the last edge of a machine cycle.
- R12: `mem_rd_o` is high for the whole fetch cycle and for the execute cycles of groups 0x3, 0x4 and opcode 0xC0, and low otherwise. It is never high together with `data_oe_o`.
- R13: A clock edge on which `halt_i` or `pause_i` is high changes no state and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low clear |
| halt_i | input | 1 | Stall request |
| pause_i | input | 1 | Second stall request, same effect |
| flag_i | input | 4 | External condition flags tested by short branches |
| data_i | input | 8 | Memory read data |
| data_o | output | 8 | Store data (accumulator) |
| data_oe_o | output | 1 | Store cycle: data_o valid, memory should write |
| addr_o | output | 16 | Memory address |
| mem_rd_o | output | 1 | Read strobe |
| q_o | output | 1 | Q output bit |
| state_code_o | output | 2 | 00 fetch, 01 execute |
| tp_early_o | output | 1 | Early timing pulse |
| tp_late_o | output | 1 | Late timing pulse |

## Verification
The hardest case to reach from the ports is a not-taken short branch whose operand sits at the last byte of a page while a register other than R0 is the program counter. Only there does the increment carry into the high byte, and only there does a following taken branch show that the high byte is kept. The stimulus program gets there in three steps. It uses loads through R0 to build a pointer in R3, switches the program counter to R3, and uses a long branch to land on a never-taken branch at 0x00FE. The whole program also runs under pseudo-random stalls that hit every phase of every cycle type. Two flag patterns drive the short branches down opposite paths.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [1:0] {
    CYC_FETCH = 2'd0,
    CYC_EXEC  = 2'd1,
    CYC_EXEC2 = 2'd2
  } cyc_e;

  localparam logic [3:0] GRP_SBR  = 4'h3;
  localparam logic [3:0] GRP_LDA  = 4'h4;
  localparam logic [3:0] GRP_STR  = 4'h5;
  localparam logic [3:0] GRP_QCTL = 4'h7;
  localparam logic [3:0] GRP_GLO  = 4'h8;
  localparam logic [3:0] GRP_GHI  = 4'h9;
  localparam logic [3:0] GRP_PLO  = 4'hA;
  localparam logic [3:0] GRP_LBR  = 4'hC;
  localparam logic [3:0] GRP_SETP = 4'hD;

  localparam logic [3:0] N_QCLR = 4'hA;
  localparam logic [3:0] N_QSET = 4'hB;
  localparam logic [3:0] N_LBR  = 4'h0;

  localparam logic [1:0] SC_FETCH = 2'b00;
  localparam logic [1:0] SC_EXEC  = 2'b01;

  localparam int NUM_FLAGS = 4;

  typedef struct packed {
    logic sbr;
    logic lbr;
    logic lda;
    logic str;
    logic glo;
    logic ghi;
    logic plo;
    logic qset;
    logic qclr;
    logic setp;
  } dec_t;
endpackage

// File: rtl/seq_timing.sv
module seq_timing #(
  parameter int CYCLE_CLKS = 8,
  parameter int TPA_PH     = 1,
  parameter int TPB_PH     = 6,
  localparam int PH_W      = $clog2(CYCLE_CLKS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            adv_i,
  output logic [PH_W-1:0] phase_o,
  output logic            cyc_end_o,
  output logic            tpa_o,
  output logic            tpb_o
);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(CYCLE_CLKS - 1);

  logic [PH_W-1:0] phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   phase_q <= '0;
    else if (adv_i) begin
      if (phase_q == LAST_PH)      phase_q <= '0;
      else                         phase_q <= phase_q + PH_W'(1);
    end
  end

  assign phase_o   = phase_q;
  assign cyc_end_o = adv_i && (phase_q == LAST_PH);
  assign tpa_o     = (phase_q == PH_W'(TPA_PH));
  assign tpb_o     = (phase_q == PH_W'(TPB_PH));
endmodule

// File: rtl/seq_regfile.sv
module seq_regfile #(
  parameter int NUM_REGS = 16,
  parameter int REG_W    = 16,
  localparam int SEL_W   = $clog2(NUM_REGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] ra_a_i,
  output logic [REG_W-1:0] rd_a_o,
  input  logic [SEL_W-1:0] ra_b_i,
  output logic [REG_W-1:0] rd_b_o,
  input  logic             we_i,
  input  logic [SEL_W-1:0] wa_i,
  input  logic [REG_W-1:0] wd_i
);
  logic [NUM_REGS-1:0][REG_W-1:0] rows;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_row
    logic [REG_W-1:0] row_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              row_q <= '0;
      else if (we_i && wa_i == SEL_W'(g))       row_q <= wd_i;
    end
    assign rows[g] = row_q;
  end

  assign rd_a_o = rows[ra_a_i];
  assign rd_b_o = rows[ra_b_i];
endmodule

// File: rtl/seq_decode.sv
module seq_decode
  import seq_pkg::*;
(
  input  logic [7:0] op_i,
  output dec_t       dec_o
);
  logic [3:0] grp, n;
  assign grp = op_i[7:4];
  assign n   = op_i[3:0];

  always_comb begin
    dec_o = '0;
    unique case (grp)
      GRP_SBR:  dec_o.sbr  = 1'b1;
      GRP_LDA:  dec_o.lda  = 1'b1;
      GRP_STR:  dec_o.str  = 1'b1;
      GRP_QCTL: begin
        dec_o.qset = (n == N_QSET);
        dec_o.qclr = (n == N_QCLR);
      end
      GRP_GLO:  dec_o.glo  = 1'b1;
      GRP_GHI:  dec_o.ghi  = 1'b1;
      GRP_PLO:  dec_o.plo  = 1'b1;
      GRP_LBR:  dec_o.lbr  = (n == N_LBR);
      GRP_SETP: dec_o.setp = 1'b1;
      default:  dec_o = '0;
    endcase
  end
endmodule

// File: rtl/seq_branch_cond.sv
module seq_branch_cond
  import seq_pkg::*;
(
  input  logic [3:0]           cond_i,
  input  logic                 q_i,
  input  logic                 d_zero_i,
  input  logic [NUM_FLAGS-1:0] flag_i,
  output logic                 take_o
);
  logic raw;

  // bit 3 inverts the sense; code 3 is a constant false
  always_comb begin
    unique case (cond_i[2:0])
      3'd0:    raw = 1'b1;
      3'd1:    raw = q_i;
      3'd2:    raw = d_zero_i;
      3'd3:    raw = 1'b0;
      default: raw = flag_i[cond_i[1:0]];
    endcase
  end

  assign take_o = raw ^ cond_i[3];
endmodule

// File: rtl/seq_core.sv
module seq_core
  import seq_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int NUM_REGS   = 16,
  parameter int CYCLE_CLKS = 8,
  parameter int TPA_PH     = 1,
  parameter int TPB_PH     = 6,
  localparam int REG_W     = 2 * DATA_W,
  localparam int SEL_W     = $clog2(NUM_REGS),
  localparam int PH_W      = $clog2(CYCLE_CLKS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 halt_i,
  input  logic                 pause_i,
  input  logic [NUM_FLAGS-1:0] flag_i,
  input  logic [DATA_W-1:0]    data_i,
  output logic [DATA_W-1:0]    data_o,
  output logic                 data_oe_o,
  output logic [REG_W-1:0]     addr_o,
  output logic                 mem_rd_o,
  output logic                 q_o,
  output logic [1:0]           state_code_o,
  output logic                 tp_early_o,
  output logic                 tp_late_o
);
  logic            adv, cyc_end;
  logic [PH_W-1:0] phase_q;

  cyc_e              cyc_q, cyc_d;
  logic [DATA_W-1:0] ir_q, ir_d, d_q, d_d, hi_q, hi_d;
  logic [SEL_W-1:0]  p_q, p_d, n_sel;
  logic              q_q, q_d;

  logic [REG_W-1:0]  r_p, r_n, wd;
  logic [SEL_W-1:0]  wa;
  logic              we;
  dec_t              dec;
  logic              take, in_exec;

  assign adv = ~(halt_i | pause_i);

  seq_timing #(
    .CYCLE_CLKS(CYCLE_CLKS),
    .TPA_PH    (TPA_PH),
    .TPB_PH    (TPB_PH)
  ) u_timing (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .adv_i    (adv),
    .phase_o  (phase_q),
    .cyc_end_o(cyc_end),
    .tpa_o    (tp_early_o),
    .tpb_o    (tp_late_o)
  );

  assign n_sel = SEL_W'(ir_q[3:0]);

  seq_regfile #(
    .NUM_REGS(NUM_REGS),
    .REG_W   (REG_W)
  ) u_rf (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ra_a_i(p_q),
    .rd_a_o(r_p),
    .ra_b_i(n_sel),
    .rd_b_o(r_n),
    .we_i  (we && cyc_end),
    .wa_i  (wa),
    .wd_i  (wd)
  );

  seq_decode u_dec (
    .op_i (ir_q),
    .dec_o(dec)
  );

  seq_branch_cond u_cond (
    .cond_i  (ir_q[3:0]),
    .q_i     (q_q),
    .d_zero_i(d_q == '0),
    .flag_i  (flag_i),
    .take_o  (take)
  );

  // Outputs derive from registered state only
  assign in_exec      = (cyc_q != CYC_FETCH);
  assign addr_o       = (cyc_q == CYC_EXEC && (dec.lda || dec.str)) ? r_n : r_p;
  assign mem_rd_o     = (cyc_q == CYC_FETCH) || (cyc_q == CYC_EXEC2)
                      || (cyc_q == CYC_EXEC && (dec.sbr || dec.lda || dec.lbr));
  assign data_oe_o    = (cyc_q == CYC_EXEC) && dec.str;
  assign data_o       = d_q;
  assign q_o          = q_q;
  assign state_code_o = in_exec ? SC_EXEC : SC_FETCH;

  // Effects of the cycle ending on this edge
  always_comb begin
    cyc_d = cyc_q;
    ir_d  = ir_q;
    p_d   = p_q;
    d_d   = d_q;
    q_d   = q_q;
    hi_d  = hi_q;
    we    = 1'b0;
    wa    = p_q;
    wd    = r_p + REG_W'(1);
    unique case (cyc_q)
      CYC_FETCH: begin
        ir_d  = data_i;
        we    = 1'b1;
        cyc_d = CYC_EXEC;
      end
      CYC_EXEC: begin
        cyc_d = CYC_FETCH;
        if (dec.sbr) begin
          we = 1'b1;
          if (take) wd = {r_p[REG_W-1:DATA_W], data_i};
        end else if (dec.lbr) begin
          we    = 1'b1;
          hi_d  = data_i;
          cyc_d = CYC_EXEC2;
        end else if (dec.lda) begin
          d_d = data_i;
          we  = 1'b1;
          wa  = n_sel;
          wd  = r_n + REG_W'(1);
        end else if (dec.glo) begin
          d_d = r_n[DATA_W-1:0];
        end else if (dec.ghi) begin
          d_d = r_n[REG_W-1:DATA_W];
        end else if (dec.plo) begin
          we = 1'b1;
          wa = n_sel;
          wd = {r_n[REG_W-1:DATA_W], d_q};
        end else if (dec.qset) begin
          q_d = 1'b1;
        end else if (dec.qclr) begin
          q_d = 1'b0;
        end else if (dec.setp) begin
          p_d = n_sel;
        end
      end
      CYC_EXEC2: begin
        we    = 1'b1;
        wd    = {hi_q, data_i};
        cyc_d = CYC_FETCH;
      end
      default: cyc_d = CYC_FETCH;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q <= CYC_FETCH;
      ir_q  <= '0;
      p_q   <= '0;
      d_q   <= '0;
      q_q   <= 1'b0;
      hi_q  <= '0;
    end else if (cyc_end) begin
      cyc_q <= cyc_d;
      ir_q  <= ir_d;
      p_q   <= p_d;
      d_q   <= d_d;
      q_q   <= q_d;
      hi_q  <= hi_d;
    end
  end
endmodule

// File: rtl/seq_core_chk.sv
module seq_core_chk #(
  parameter int CYCLE_CLKS = 8,
  parameter int ADDR_W     = 16,
  localparam int PH_W      = $clog2(CYCLE_CLKS)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              halt_i,
  input logic              pause_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              mem_rd_o,
  input logic              data_oe_o,
  input logic              q_o,
  input logic [1:0]        state_code_o,
  input logic              tp_early_o,
  input logic              tp_late_o,
  input logic [PH_W-1:0]   phase_q
);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(CYCLE_CLKS - 1);

  // R2
  tpa_single_clk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tp_early_o && !halt_i && !pause_i) |=> !tp_early_o);

  // R2
  tp_disjoint_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tp_early_o |-> !tp_late_o);

  // R3
  fetch_reads_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_code_o == 2'b00) |-> mem_rd_o);

  // R7
  store_in_exec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> (state_code_o == 2'b01));

  // R8
  q_at_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(q_o) |-> ($past(phase_q) == LAST_PH));

  // R11
  sc_at_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(state_code_o) |-> ($past(phase_q) == LAST_PH));

  // R12
  rd_wr_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && data_oe_o));

  // R13
  stall_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_i || pause_i) |=> ($stable(addr_o) && $stable(state_code_o)
                             && $stable(q_o) && $stable(tp_early_o)
                             && $stable(tp_late_o)));
endmodule

bind seq_core seq_core_chk #(
  .CYCLE_CLKS(CYCLE_CLKS),
  .ADDR_W    (REG_W)
) i_seq_core_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .halt_i      (halt_i),
  .pause_i     (pause_i),
  .addr_o      (addr_o),
  .mem_rd_o    (mem_rd_o),
  .data_oe_o   (data_oe_o),
  .q_o         (q_o),
  .state_code_o(state_code_o),
  .tp_early_o  (tp_early_o),
  .tp_late_o   (tp_late_o),
  .phase_q     (phase_q)
);

// File: tb/test_seq_core.sv
module test_seq_core;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        halt = 1'b0;
  logic        pause = 1'b0;
  logic [3:0]  flags = 4'b0101;
  logic [7:0]  data_i, data_o;
  logic        data_oe, mem_rd, q, tpa, tpb;
  logic [15:0] addr;
  logic [1:0]  sc;

  logic [7:0]  mem   [0:1023];
  logic [7:0]  m_mem [0:1023];

  int errors = 0;
  int checks = 0;
  bit cmp_en = 1'b0;
  bit stall_en = 1'b0;
  bit done = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign data_i = mem[addr[9:0]];

  seq_core i_seq_core (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .halt_i      (halt),
    .pause_i     (pause),
    .flag_i      (flags),
    .data_i      (data_i),
    .data_o      (data_o),
    .data_oe_o   (data_oe),
    .addr_o      (addr),
    .mem_rd_o    (mem_rd),
    .q_o         (q),
    .state_code_o(sc),
    .tp_early_o  (tpa),
    .tp_late_o   (tpb)
  );

  // bench memory takes writes from the design
  always @(posedge clk)
    if (rst_n && data_oe && tpb && !halt && !pause) mem[addr[9:0]] <= data_o;

  // ---------------- reference model ----------------
  logic [15:0] m_r [16];
  int          m_p, m_ph, m_cyc, mn;
  logic [7:0]  m_ir, m_d, m_hi, m_b;
  logic [15:0] m_a;
  bit          m_q;

  function automatic logic [15:0] m_addr();
    if (m_cyc == 1 && (m_ir[7:4] == 4'h4 || m_ir[7:4] == 4'h5)) return m_r[m_ir[3:0]];
    return m_r[m_p];
  endfunction

  function automatic bit m_rd();
    if (m_cyc == 0 || m_cyc == 2) return 1'b1;
    return (m_ir[7:4] == 4'h3) || (m_ir[7:4] == 4'h4) || (m_ir == 8'hC0);
  endfunction

  function automatic bit m_take(logic [3:0] c);
    case (c)
      4'h0: return 1'b1;
      4'h1: return m_q;
      4'h2: return m_d == 8'h00;
      4'h3: return 1'b0;
      4'h4: return flags[0];
      4'h5: return flags[1];
      4'h6: return flags[2];
      4'h7: return flags[3];
      4'h8: return 1'b0;
      4'h9: return !m_q;
      4'hA: return m_d != 8'h00;
      4'hB: return 1'b1;
      4'hC: return !flags[0];
      4'hD: return !flags[1];
      4'hE: return !flags[2];
      default: return !flags[3];
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) m_r[i] = 16'h0000;
      m_p = 0; m_ph = 0; m_cyc = 0;
      m_ir = 8'h00; m_d = 8'h00; m_hi = 8'h00; m_q = 1'b0;
    end else if (!halt && !pause) begin
      if (m_ph != 7) m_ph = m_ph + 1;
      else begin
        m_ph = 0;
        m_a  = m_addr();
        m_b  = m_mem[m_a[9:0]];
        mn   = int'(m_ir[3:0]);
        if (m_cyc == 0) begin
          m_ir = m_b;
          m_r[m_p] = m_r[m_p] + 16'd1;
          m_cyc = 1;
        end else if (m_cyc == 1) begin
          m_cyc = 0;
          case (m_ir[7:4])
            4'h3: if (m_take(m_ir[3:0])) m_r[m_p][7:0] = m_b;
                  else m_r[m_p] = m_r[m_p] + 16'd1;
            4'h4: begin m_d = m_b; m_r[mn] = m_r[mn] + 16'd1; end
            4'h5: m_mem[m_a[9:0]] = m_d;
            4'h7: if (mn == 11) m_q = 1'b1; else if (mn == 10) m_q = 1'b0;
            4'h8: m_d = m_r[mn][7:0];
            4'h9: m_d = m_r[mn][15:8];
            4'hA: m_r[mn][7:0] = m_d;
            4'hC: if (mn == 0) begin
                    m_hi = m_b;
                    m_r[m_p] = m_r[m_p] + 16'd1;
                    m_cyc = 2;
                  end
            4'hD: m_p = mn;
            default: ;
          endcase
        end else begin
          m_r[m_p] = {m_hi, m_b};
          m_cyc = 0;
        end
      end
    end
  end

  // ---------------- checking ----------------
  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en && rst_n) begin
      chk("R3 R10 addr", addr, m_addr());
      chk("R12 mem_rd", 16'(mem_rd), 16'(m_rd()));
      chk("R7 data_oe", 16'(data_oe), 16'(m_cyc == 1 && m_ir[7:4] == 4'h5));
      if (m_cyc == 1 && m_ir[7:4] == 4'h5) chk("R7 R6 data_o", 16'(data_o), 16'(m_d));
      chk("R8 q", 16'(q), 16'(m_q));
      chk("R11 state", 16'(sc), (m_cyc == 0) ? 16'd0 : 16'd1);
      chk("R2 tpa", 16'(tpa), 16'(m_ph == 1));
      chk("R2 tpb", 16'(tpb), 16'(m_ph == 6));
    end
  end

  task automatic put(int a, logic [7:0] v);
    mem[a] = v;
    m_mem[a] = v;
  endtask

  task automatic load_prog();
    for (int i = 0; i < 1024; i++) put(i, 8'h00);
    put(16'h00, 8'h7B);
    put(16'h01, 8'h40); put(16'h02, 8'h55);
    put(16'h03, 8'hA1);
    put(16'h04, 8'h40); put(16'h05, 8'h80);
    put(16'h06, 8'hA2);
    put(16'h07, 8'h81);
    put(16'h08, 8'h52);
    put(16'h09, 8'h92);
    put(16'h0A, 8'h32); put(16'h0B, 8'h10);
    put(16'h10, 8'h31); put(16'h11, 8'h20);
    put(16'h20, 8'h7A);
    put(16'h21, 8'h31); put(16'h22, 8'h30);
    put(16'h23, 8'h34); put(16'h24, 8'h40);
    put(16'h25, 8'h30); put(16'h26, 8'h40);
    put(16'h40, 8'h35); put(16'h41, 8'h50);
    put(16'h42, 8'h3C); put(16'h43, 8'h50);
    put(16'h44, 8'h3D); put(16'h45, 8'h48);
    put(16'h46, 8'h30); put(16'h47, 8'h48);
    put(16'h48, 8'h40); put(16'h49, 8'h60);
    put(16'h4A, 8'hA3);
    put(16'h4B, 8'hC0); put(16'h4C, 8'h01); put(16'h4D, 8'h20);
    put(16'h50, 8'h30); put(16'h51, 8'h44);
    put(16'h60, 8'h7B);
    put(16'h61, 8'hE5);
    put(16'h62, 8'hC0); put(16'h63, 8'h00); put(16'h64, 8'hFE);
    put(16'hFE, 8'h38); put(16'hFF, 8'h77);
    put(16'h100, 8'h30); put(16'h101, 8'h00);
    put(16'h120, 8'h42);
    put(16'h121, 8'h52);
    put(16'h122, 8'hE5);
    put(16'h123, 8'hD3);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      lfsr  = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      halt  = stall_en && (lfsr[2:0] == 3'd0);
      pause = stall_en && (lfsr[6:4] == 3'd7);
    end
    @(negedge clk);
    halt  = 1'b0;
    pause = 1'b0;
  endtask

  task automatic reset_and_check();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 addr", addr, 16'h0000);
    chk("R1 state", 16'(sc), 16'd0);
    chk("R1 q", 16'(q), 16'd0);
    chk("R1 rd", 16'(mem_rd), 16'd1);
    chk("R1 oe", 16'(data_oe), 16'd0);
    chk("R1 tpa", 16'(tpa), 16'd0);
    rst_n = 1'b1;
  endtask

  task automatic final_checks();
    chk("R7 R6 store via get-low", 16'(mem[16'h80]), 16'h0055);
    chk("R7 load then store", 16'(mem[16'h81]), 16'h0055);
    chk("R8 q set", 16'(q), 16'd1);
    // loop at 0x0100 proves carry on skip, high byte kept (R4), long branch (R5), pointer switch (R9)
    while (!(tpa && sc == 2'b00)) @(negedge clk);
    chk("R4 R5 R9 final fetch address", addr, 16'h0100);
  endtask

  int k;
  logic [15:0] s_addr;
  logic [1:0]  s_sc;
  logic        s_q, s_tpa, s_tpb, s_rd;

  initial begin
    load_prog();
    flags = 4'b0101;
    reset_and_check();
    cmp_en = 1'b1;

    // R2: period of the early pulse
    while (!tpa) @(negedge clk);
    k = 0;
    do begin @(negedge clk); k++; end while (!tpa);
    chk("R2 period", 16'(k), 16'd8);

    // R13: hold each stall input
    for (int s = 0; s < 2; s++) begin
      repeat (3) @(negedge clk);
      s_addr = addr; s_sc = sc; s_q = q; s_tpa = tpa; s_tpb = tpb; s_rd = mem_rd;
      if (s == 0) halt = 1'b1; else pause = 1'b1;
      repeat (12) @(negedge clk);
      chk("R13 addr held", addr, s_addr);
      chk("R13 state held", 16'(sc), 16'(s_sc));
      chk("R13 pulses held", 16'({tpa, tpb, q, mem_rd}), 16'({s_tpa, s_tpb, s_q, s_rd}));
      halt = 1'b0; pause = 1'b0;
    end

    stall_en = 1'b1;
    run(3000);
    final_checks();

    // second pass: opposite flag pattern, restart from reset
    load_prog();
    flags = 4'b1010;
    reset_and_check();
    run(3000);
    final_checks();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R13 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule